// File: doc/BRIEF.md
# Microcontroller Port Register File

This block places one I/O port of a programmable-logic device on the synchronous bus of an 8-bit microcontroller. It contains a port output register, a direction register and a per-bit mask register. It also gives the bus read access to the live pin levels, to the effective output enables, to the logic-array output flip-flops and to the input-cell latches. Each pin is driven when its direction bit is set or when the logic array asserts a product-term enable for that pin. The block reports the combined enable back to the bus.

A bus write to the output-cell offset does not store anything in this block. It produces a one-cycle load request toward the logic-array output flip-flops. The load enable for each bit is the inverse of its mask bit, so masked bits keep their state. Read data is combinational. It is valid in the same cycle as the read strobe and is 0x00 while the strobe is low.

Top module: `port_regfile`

## Requirements
- R1: After reset, the output register, the direction register and the mask register are all 0x00. `pin_out` is therefore 0, `pin_oe` equals `array_oe`, and `ocell_ld_en` is 0.
- R2: A write to offset 1 stores the byte in the output register. A read at offset 1 returns that byte, and `pin_out` shows it from the next cycle on.
- R3: A read at offset 0 returns `pin_in` as it is in the same cycle. No value is stored.
- R4: A write to offset 2 stores the direction byte, and a read at offset 2 returns it. `pin_oe` equals the direction byte OR `array_oe`, bit by bit, where 1 means the pin is driven.
- R5: A read at offset 6 returns the current `pin_oe`.
- R6: During a write cycle at offset 3, `ocell_ld_en` equals the inverted mask and `ocell_ld_data` equals the written byte. In every other cycle both are 0.
- R7: A write to offset 4 stores the mask, and a read at offset 4 returns it. A mask bit of 1 blocks the load of that output flip-flop.
- R8: A read at offset 3 returns `ocell_q`, and a read at offset 5 returns `icell_q`.
- R9: Writes to offsets 0, 5, 6 and 7 change no register. A read at offset 7 returns 0x00, and `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as the read strobe |
| pin_in | input | 8 | Current pin levels |
| array_oe | input | 8 | Product-term output enables from the logic array |
| ocell_q | input | 8 | Current outputs of the array output flip-flops |
| icell_q | input | 8 | Values held by the input cells |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Effective pin driver enables |
| ocell_ld_en | output | 8 | Per-bit load strobe for the output flip-flops |
| ocell_ld_data | output | 8 | Load data for the output flip-flops |

## Verification
The bench first writes a partial mask and then writes to the output-cell offset. A design that ignores the mask, or that leaves the mask uninverted, would load exactly the wrong bits. The bench also samples the load strobe in the cycle after the write, to find a strobe that is held longer than one cycle. The bench changes `array_oe` while the direction bits are fixed. A design that uses only the direction register would leave pins undriven and would report the wrong enable at offset 6. Writes to the read-only offsets and to the unused offset are followed by readback of every stored register, so a decoder that aliases those offsets onto writable registers is caught. Data In is read twice with different pin levels, which exposes a design that returns a stored copy.

// File: rtl/port_regfile.sv
module port_regfile #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  array_oe,
  input  logic [W-1:0]  ocell_q,
  input  logic [W-1:0]  icell_q,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  ocell_ld_en,
  output logic [W-1:0]  ocell_ld_data
);
  localparam logic [AW-1:0] OFS_DIN  = AW'(0);
  localparam logic [AW-1:0] OFS_DOUT = AW'(1);
  localparam logic [AW-1:0] OFS_DIR  = AW'(2);
  localparam logic [AW-1:0] OFS_OCEL = AW'(3);
  localparam logic [AW-1:0] OFS_MASK = AW'(4);
  localparam logic [AW-1:0] OFS_ICEL = AW'(5);
  localparam logic [AW-1:0] OFS_OE   = AW'(6);

  logic [W-1:0] dout_q, dir_q, mask_q, rd_mux;
  logic         ocel_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DOUT: dout_q <= bus_wdata;
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_MASK: mask_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign pin_out       = dout_q;
  assign pin_oe        = dir_q | array_oe;
  assign ocel_wr       = bus_wr && (bus_addr == OFS_OCEL);
  assign ocell_ld_en   = ocel_wr ? ~mask_q : '0;
  assign ocell_ld_data = ocel_wr ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      OFS_DIN:  rd_mux = pin_in;
      OFS_DOUT: rd_mux = dout_q;
      OFS_DIR:  rd_mux = dir_q;
      OFS_OCEL: rd_mux = ocell_q;
      OFS_MASK: rd_mux = mask_q;
      OFS_ICEL: rd_mux = icell_q;
      OFS_OE:   rd_mux = pin_oe;
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  a_r2_dout_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DOUT) |=> (pin_out == $past(bus_wdata)));

  a_r4_dir_enables_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

  a_r6_load_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ocell_ld_en != '0) |-> (bus_wr && bus_addr == OFS_OCEL));

  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_DIN || bus_addr == OFS_ICEL || bus_addr == OFS_OE || bus_addr == AW'(7)))
    |=> (pin_out == $past(pin_out)));

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_port_regfile.sv
module test_port_regfile;
  logic       clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pin_in = 0, array_oe = 0, ocell_q = 0, icell_q = 0;
  logic [7:0] pin_out, pin_oe, ocell_ld_en, ocell_ld_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  port_regfile i_port_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .array_oe(array_oe),
    .ocell_q(ocell_q), .icell_q(icell_q), .pin_out(pin_out), .pin_oe(pin_oe),
    .ocell_ld_en(ocell_ld_en), .ocell_ld_data(ocell_ld_data));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #5 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1, v); check("R1 dout", v, 8'h00);
    rd(2, v); check("R1 dir", v, 8'h00);
    rd(4, v); check("R1 mask", v, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 ld_en", ocell_ld_en, 8'h00);
  endtask

  task automatic t_data_in;
    logic [7:0] v;
    pin_in = 8'hA5; rd(0, v); check("R3 din", v, 8'hA5);
    pin_in = 8'h3C; rd(0, v); check("R3 din live", v, 8'h3C);
  endtask

  task automatic t_data_out;
    logic [7:0] v;
    wr(1, 8'h5A);
    rd(1, v); check("R2 readback", v, 8'h5A);
    check("R2 pin_out", pin_out, 8'h5A);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    array_oe = 8'h00;
    wr(2, 8'h0F);
    rd(2, v); check("R4 dir readback", v, 8'h0F);
    check("R4 pin_oe dir", pin_oe, 8'h0F);
    array_oe = 8'h30; #1;
    check("R4 pin_oe or", pin_oe, 8'h3F);
    rd(6, v); check("R5 enable readback", v, 8'h3F);
    array_oe = 8'h00;
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(4, 8'hF0);
    rd(4, v); check("R7 mask readback", v, 8'hF0);
    @(negedge clk); bus_addr = 3; bus_wdata = 8'hAA; bus_wr = 1;
    #5 check("R6 ld_en masked", ocell_ld_en, 8'h0F);
    check("R6 ld_data", ocell_ld_data, 8'hAA);
    @(negedge clk); bus_wr = 0;
    #5 check("R6 ld_en one cycle", ocell_ld_en, 8'h00);
    wr(4, 8'h00);
    @(negedge clk); bus_addr = 3; bus_wdata = 8'h11; bus_wr = 1;
    #5 check("R7 unmasked load", ocell_ld_en, 8'hFF);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic t_cells;
    logic [7:0] v;
    ocell_q = 8'hC3; icell_q = 8'h96;
    rd(3, v); check("R8 ocell read", v, 8'hC3);
    rd(5, v); check("R8 icell read", v, 8'h96);
  endtask

  task automatic t_ro;
    logic [7:0] v;
    wr(0, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    rd(1, v); check("R9 dout kept", v, 8'h5A);
    rd(2, v); check("R9 dir kept", v, 8'h0F);
    rd(4, v); check("R9 mask kept", v, 8'h00);
    check("R9 pin_out kept", pin_out, 8'h5A);
    rd(7, v); check("R9 unused read", v, 8'h00);
    @(negedge clk); bus_addr = 1; #5;
    check("R9 idle rdata", bus_rdata, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 00 expected 01");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_data_in;
    t_data_out;
    t_dir;
    t_mask;
    t_cells;
    t_ro;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule